// File: doc/BRIEF.md
# SDRAM Refresh Command Sequencer

This block sits on the controller side of a DDR SDRAM interface and owns the refresh and low-power command traffic. A host asks for an auto-refresh, for entry into self-refresh, or for exit from self-refresh. The block then drives the four command strobes (chip select, row strobe, column strobe and write enable), the all-banks address bit and the clock enable. Every spacing it enforces is a parameter counted in clock cycles.

A one-bit open-bank tracker records whether any row may still be active. When that tracker is set, every refresh or self-refresh entry begins with a precharge of all banks. The refresh command follows only after the precharge recovery time. After an auto-refresh, the `ready` flag stays low for one full row cycle (row-active time plus precharge time). After a self-refresh exit, `ready` stays low while the clock enable is held high for the power-down exit time, and then for the longer of the exit spacing and the DLL relock count. While `ready` is low the host must not activate a row.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset the strobes read all high (deselect, pattern cs/ras/cas/we = 1111), `a10` is low, `cke` is high, `ready` is high and `sleep` is low.
- R2: In every cycle in which no command is issued, the strobes read 1111. A command (chip select low) appears only while `ready` is low.
- R3: When a request is accepted with the open-bank flag set, precharge-all (pattern 0010, `a10` high, `cke` high) appears on the first cycle after the accepting edge. The refresh pattern 0001 follows exactly T_RP cycles after the precharge cycle.
- R4: When a request is accepted with the open-bank flag clear, no precharge is issued. The refresh pattern 0001 appears on the first cycle after the accepting edge.
- R5: For an auto-refresh, `ready` is low from the first cycle after the accepting edge. It returns high exactly T_RAS+T_RP cycles after the refresh cycle. The clock enable stays high throughout.
- R6: A pulse on `act_done` sets the open-bank flag. Issuing precharge-all clears it, so a following request with no new activate skips the precharge.
- R7: Self-refresh entry drives the refresh pattern 0001 with `cke` low on that cycle. `cke` then stays low and `sleep` stays high until an exit request.
- R8: While `sleep` is high, auto-refresh and self-refresh entry requests are ignored: the strobes stay 1111 and `cke` stays low.
- R9: An exit request during sleep raises `cke` on the next cycle with the strobes at 1111. `ready` then stays low for T_PDEX + max(T_XSC, T_RELOCK) cycles from that cycle, with only deselects issued.
- R10: Requests arriving while `ready` is low and the block is not sleeping are dropped, not queued. No extra command follows once `ready` returns.
- R11: When auto-refresh and self-refresh entry are requested in the same idle cycle, the auto-refresh wins and the block does not enter self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| aref_req | input | 1 | Auto-refresh request, sampled while idle |
| sref_enter_req | input | 1 | Self-refresh entry request, sampled while idle |
| sref_exit_req | input | 1 | Self-refresh exit request, sampled while sleeping |
| act_done | input | 1 | Host reports that it issued an activate |
| cs_n | output | 1 | Chip select strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable strobe, active low |
| a10 | output | 1 | All-banks bit, high with precharge-all |
| cke | output | 1 | Clock enable to the device |
| ready | output | 1 | High when an activate is permitted and a request can be taken |
| sleep | output | 1 | High while the device is held in self-refresh |

## Verification
A stale open-bank flag appears at the pins on the first cycle after a request is accepted. A lost activate shows as a refresh with no precharge before it. A flag that is never cleared shows as an unneeded precharge on a request that follows. A counter loaded with the wrong value moves the refresh command, or the rising edge of `ready`, by one or more cycles. The bench checks the exact cycle, so a one-cycle shift fails at once. A state that leaves self-refresh wrongly shows as `cke` rising or a non-deselect pattern appearing while `sleep` is high, in the cycle it happens.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRP,
        ST_WRC,
        ST_SLEEP,
        ST_XPD,
        ST_XWAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_DESL,
        CMD_PALL,
        CMD_REF
    } cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    function automatic pins_t cmd_pins(cmd_e c);
        pins_t p;
        case (c)
            CMD_PALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            default:  p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic act_done,
    input  logic pall_issued,
    output logic bank_open
);
    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (act_done)    open_d = 1'b1;
        if (pall_issued) open_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end

    assign bank_open = open_q;
endmodule

// File: rtl/cmd_encoder.sv
module cmd_encoder
    import sdram_refresh_pkg::*;
(
    input  cmd_e cmd,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic a10
);
    pins_t p;

    always_comb begin
        p     = cmd_pins(cmd);
        cs_n  = p.cs_n;
        ras_n = p.ras_n;
        cas_n = p.cas_n;
        we_n  = p.we_n;
        a10   = (cmd == CMD_PALL);
    end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
    import sdram_refresh_pkg::*;
#(
    parameter int T_RP     = 3,
    parameter int T_RAS    = 6,
    parameter int T_XSC    = 20,
    parameter int T_PDEX   = 2,
    parameter int T_RELOCK = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aref_req,
    input  logic sref_enter_req,
    input  logic sref_exit_req,
    input  logic act_done,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic a10,
    output logic cke,
    output logic ready,
    output logic sleep
);
    localparam int T_RC    = T_RAS + T_RP;
    localparam int T_XWAIT = (T_XSC > T_RELOCK) ? T_XSC : T_RELOCK;
    localparam int T_M1    = (T_RC > T_XWAIT) ? T_RC : T_XWAIT;
    localparam int T_MAX   = (T_M1 > T_PDEX) ? T_M1 : T_PDEX;
    localparam int CW      = $clog2(T_MAX + 1);

    localparam logic [CW-1:0] RP_L    = CW'(T_RP - 1);
    localparam logic [CW-1:0] RC_L    = CW'(T_RC - 1);
    localparam logic [CW-1:0] PDEX_L  = CW'(T_PDEX - 1);
    localparam logic [CW-1:0] XWAIT_L = CW'(T_XWAIT - 1);

    typedef struct packed {
        seq_state_e state;
        cmd_e       cmd;
        logic       cke;
        logic       ready;
        logic       goal_sref;
    } seq_t;

    seq_t            s_d, s_q;
    logic            tmr_load;
    logic [CW-1:0]   tmr_val;
    logic            tmr_zero;
    logic            bank_open;

    seq_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    bank_tracker u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_done    (act_done),
        .pall_issued (s_q.cmd == CMD_PALL),
        .bank_open   (bank_open)
    );

    cmd_encoder u_enc (
        .cmd   (s_q.cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (a10)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_DESL;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (s_q.state)
            ST_IDLE: begin
                if (aref_req || sref_enter_req) begin
                    s_d.ready     = 1'b0;
                    s_d.goal_sref = !aref_req;
                    if (bank_open) begin
                        s_d.cmd   = CMD_PALL;
                        s_d.state = ST_WRP;
                        tmr_load  = 1'b1;
                        tmr_val   = RP_L;
                    end else if (!aref_req) begin
                        s_d.cmd   = CMD_REF;
                        s_d.cke   = 1'b0;
                        s_d.state = ST_SLEEP;
                    end else begin
                        s_d.cmd   = CMD_REF;
                        s_d.state = ST_WRC;
                        tmr_load  = 1'b1;
                        tmr_val   = RC_L;
                    end
                end
            end
            ST_WRP: begin
                if (tmr_zero) begin
                    s_d.cmd = CMD_REF;
                    if (s_q.goal_sref) begin
                        s_d.cke   = 1'b0;
                        s_d.state = ST_SLEEP;
                    end else begin
                        s_d.state = ST_WRC;
                        tmr_load  = 1'b1;
                        tmr_val   = RC_L;
                    end
                end
            end
            ST_WRC: begin
                if (tmr_zero) begin
                    s_d.state = ST_IDLE;
                    s_d.ready = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (sref_exit_req) begin
                    s_d.cke   = 1'b1;
                    s_d.state = ST_XPD;
                    tmr_load  = 1'b1;
                    tmr_val   = PDEX_L;
                end
            end
            ST_XPD: begin
                if (tmr_zero) begin
                    s_d.state = ST_XWAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = XWAIT_L;
                end
            end
            ST_XWAIT: begin
                if (tmr_zero) begin
                    s_d.state = ST_IDLE;
                    s_d.ready = 1'b1;
                end
            end
            default: begin
                s_d.state = ST_IDLE;
                s_d.cke   = 1'b1;
                s_d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state     <= ST_IDLE;
            s_q.cmd       <= CMD_DESL;
            s_q.cke       <= 1'b1;
            s_q.ready     <= 1'b1;
            s_q.goal_sref <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cke   = s_q.cke;
    assign ready = s_q.ready;
    assign sleep = (s_q.state == ST_SLEEP);
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk #(
    parameter int T_RP = 3
) (
    input logic clk,
    input logic rst_n,
    input logic sref_exit_req,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic a10,
    input logic cke,
    input logic ready,
    input logic sleep
);
    logic [3:0]  pins;
    logic        is_pall, is_ref;
    logic [15:0] since_pall;
    logic        pall_pend;

    assign pins    = {cs_n, ras_n, cas_n, we_n};
    assign is_pall = (pins == 4'b0010);
    assign is_ref  = (pins == 4'b0001);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_pall <= '0;
            pall_pend  <= 1'b0;
        end else begin
            if (is_pall) begin
                since_pall <= 16'd1;
                pall_pend  <= 1'b1;
            end else begin
                if (since_pall != 16'hFFFF) since_pall <= since_pall + 1'b1;
                if (is_ref) pall_pend <= 1'b0;
            end
        end
    end

    // R2
    cmd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !ready);

    // R3
    pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |-> (a10 && cke));

    // R3
    ref_after_rp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && pall_pend) |-> (since_pall >= 16'(T_RP)));

    // R7
    sleep_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !cke);

    // R8
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !sref_exit_req) |=> (sleep && !cke && cs_n));

    // R9
    exit_desl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cs_n && !ready && !sleep));
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(.T_RP(T_RP)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sref_exit_req (sref_exit_req),
    .cs_n          (cs_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .we_n          (we_n),
    .a10           (a10),
    .cke           (cke),
    .ready         (ready),
    .sleep         (sleep)
);

// File: tb/sdram_refresh_seq_test.sv
module sdram_refresh_seq_test;
    localparam int T_RP     = 3;
    localparam int T_RAS    = 6;
    localparam int T_XSC    = 20;
    localparam int T_PDEX   = 2;
    localparam int T_RELOCK = 200;
    localparam int T_RC     = T_RAS + T_RP;
    localparam int T_XW     = (T_XSC > T_RELOCK) ? T_XSC : T_RELOCK;

    localparam logic [3:0] P_DESL = 4'b1111;
    localparam logic [3:0] P_PALL = 4'b0010;
    localparam logic [3:0] P_REF  = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aref_req = 1'b0, sref_enter_req = 1'b0, sref_exit_req = 1'b0, act_done = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, a10, cke, ready, sleep;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_refresh_seq #(
        .T_RP(T_RP), .T_RAS(T_RAS), .T_XSC(T_XSC), .T_PDEX(T_PDEX), .T_RELOCK(T_RELOCK)
    ) uut (
        .clk(clk), .rst_n(rst_n), .aref_req(aref_req), .sref_enter_req(sref_enter_req),
        .sref_exit_req(sref_exit_req), .act_done(act_done), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .a10(a10), .cke(cke), .ready(ready), .sleep(sleep)
    );

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_act();
        act_done = 1'b1; step(); act_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pins", pins(), P_DESL);
        check("R1 a10", a10, 0);
        check("R1 cke", cke, 1);
        check("R1 ready", ready, 1);
        check("R1 sleep", sleep, 0);
        for (int i = 0; i < 4; i++) begin
            step();
            check("R2 idle desl", pins(), P_DESL);
        end
    endtask

    task automatic t_aref_open();
        int bad = 0;
        pulse_act();
        aref_req = 1'b1; step(); aref_req = 1'b0;
        check("R3 pall", pins(), P_PALL);
        check("R3 a10", a10, 1);
        check("R5 ready low", ready, 0);
        for (int i = 0; i < T_RP - 1; i++) begin
            step();
            if (pins() != P_DESL) bad++;
        end
        check("R3 desl gap", bad, 0);
        step();
        check("R3 ref at T_RP", pins(), P_REF);
        check("R5 cke high", cke, 1);
        bad = 0;
        for (int i = 0; i < T_RC - 1; i++) begin
            step();
            if (ready || pins() != P_DESL || !cke) bad++;
        end
        check("R5 hold busy", bad, 0);
        step();
        check("R5 ready at T_RC", ready, 1);
    endtask

    task automatic t_aref_closed();
        aref_req = 1'b1; step(); aref_req = 1'b0;
        check("R4 R6 ref no pall", pins(), P_REF);
        check("R4 a10", a10, 0);
        for (int i = 0; i < T_RC - 1; i++) step();
        check("R5 still busy", ready, 0);
        step();
        check("R5 ready", ready, 1);
    endtask

    task automatic t_busy_ignore();
        int bad = 0;
        aref_req = 1'b1; step(); aref_req = 1'b0;
        step();
        aref_req = 1'b1; sref_enter_req = 1'b1; step();
        aref_req = 1'b0; sref_enter_req = 1'b0;
        for (int i = 0; i < T_RC - 2; i++) step();
        check("R10 ready back", ready, 1);
        for (int i = 0; i < 6; i++) begin
            step();
            if (pins() != P_DESL || !ready || sleep) bad++;
        end
        check("R10 no queued cmd", bad, 0);
    endtask

    task automatic t_priority();
        aref_req = 1'b1; sref_enter_req = 1'b1; step();
        aref_req = 1'b0; sref_enter_req = 1'b0;
        check("R11 ref issued", pins(), P_REF);
        check("R11 cke high", cke, 1);
        check("R11 not sleep", sleep, 0);
        for (int i = 0; i < T_RC; i++) step();
        check("R11 ready", ready, 1);
    endtask

    task automatic t_sref();
        int bad = 0;
        pulse_act();
        sref_enter_req = 1'b1; step(); sref_enter_req = 1'b0;
        check("R7 pall first", pins(), P_PALL);
        for (int i = 0; i < T_RP; i++) step();
        check("R7 sref code", pins(), P_REF);
        check("R7 cke low", cke, 0);
        check("R7 sleep", sleep, 1);
        aref_req = 1'b1; sref_enter_req = 1'b1; step();
        aref_req = 1'b0; sref_enter_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (pins() != P_DESL || cke || !sleep || ready) bad++;
            step();
        end
        check("R8 ignored while asleep", bad, 0);
        sref_exit_req = 1'b1; step(); sref_exit_req = 1'b0;
        check("R9 cke up", cke, 1);
        check("R9 desl", pins(), P_DESL);
        check("R9 sleep off", sleep, 0);
        bad = 0;
        for (int i = 0; i < T_PDEX + T_XW - 1; i++) begin
            if (ready || pins() != P_DESL || !cke) bad++;
            step();
        end
        if (ready || pins() != P_DESL) bad++;
        check("R9 exit wait", bad, 0);
        step();
        check("R9 ready after exit", ready, 1);
    endtask

    task automatic t_sref_closed();
        sref_enter_req = 1'b1; step(); sref_enter_req = 1'b0;
        check("R4 R7 direct sref", pins(), P_REF);
        check("R7 cke low direct", cke, 0);
        sref_exit_req = 1'b1; step(); sref_exit_req = 1'b0;
        for (int i = 0; i < T_PDEX + T_XW; i++) step();
        check("R9 ready direct", ready, 1);
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_aref_open();
        t_aref_closed();
        t_busy_ignore();
        t_priority();
        t_sref();
        t_sref_closed();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule